// File: doc/BRIEF.md
# Timed Test Sequence Controller

This controller drives a line test pattern generator through one of four named test sequences. The caller picks a sequence and issues a start command. The controller then presents one pattern code after another on its pattern-select output and counts whole seconds from an external one-second tick. It also opens a monitor window during which an external error checker may report bit errors. Pattern generation and error detection are done by neighbouring blocks; this block only orders, times and scores the steps.

The quick and long sequences share one seven-step list. The list ends with two octet-based stress patterns, and its all-zeros step is left out unless zero-substitution line coding is enabled. The quick sequence spends five seconds on each step, while the long one uses a programmable step length. The multiple-pattern sequence and the bridge-tap sequence each have fixed transmit times, and only the tail of each transmit interval is monitored, so the far-end receiver has time to resynchronise first. After each step the controller reports that step's pass or fail result. After the last step it raises a one-cycle done flag together with the result of the whole sequence.

Top module: `test_seq_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `monEn`, `stepValid`, `done` and `overallPass` are 0, and `patSel` shows the idle code 0.
- R2: Pattern codes are 0 all ones, 1 one-in-8, 2 two-in-8, 3 three-in-24, 4 suppressed 20-bit PRBS, 5 all zeros, and 6 to 13 eight octet stress patterns. With `seqSel`=0 (quick), the steps are codes 3,1,4,0,5,6,7. Each step lasts 5 ticks, and `monEn` is 1 for the whole step.
- R3: In the quick and long sequences, when `b8zsOn` was 0 at the start command, the all-zeros step (list position 4) is skipped. Code 5 never appears, and no report is made for position 4.
- R4: With `seqSel`=1 (long), the steps are those of R2 and each lasts `longSecs` ticks, sampled at start. A value of 0 is treated as 1. `monEn` is 1 for the whole step.
- R5: With `seqSel`=2 (multiple), the steps are codes 0,1,2,3,4. Each lasts 180 ticks, and `monEn` is 0 for the first 5 ticks of a step and 1 for the remaining 175.
- R6: With `seqSel`=3 (bridge tap), there are 21 steps. Position 0 is code 0 and position 20 is code 4, and position p from 1 to 19 is code 6+((p-1) mod 8). Each step lasts 30 ticks, and `monEn` is 1 only during the last 23.
- R7: A step fails when `errStrobe` is 1 in any cycle in which `monEn` is 1, including the cycle of the step's closing tick. An error strobe while `monEn` is 0 has no effect on the result.
- R8: One cycle after the clock in which a step's closing tick is sampled, `stepValid` pulses for one cycle. In that cycle `stepNum` gives the list position and `stepPass` gives the result.
- R9: `overallPass` is 1 from a start command until a failing step is reported. It is the AND of all executed steps, and it holds after completion. `done` pulses for one cycle together with the last step's `stepValid`, and `busy` then falls.
- R10: A start command while a sequence runs restarts it from position 0 with cleared results. The aborted step is not reported, and a tick in the same cycle as the start command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| seqSel | input | 2 | Sequence: 0 quick, 1 long, 2 multiple, 3 bridge tap; sampled at start |
| start | input | 1 | Start or restart command |
| secTick | input | 1 | One-cycle pulse once per second |
| b8zsOn | input | 1 | Zero-substitution line coding enabled; sampled at start |
| longSecs | input | 16 | Step length in seconds for the long sequence |
| errStrobe | input | 1 | Bit error event from the external checker |
| patSel | output | 4 | Pattern code for the generator |
| monEn | output | 1 | Monitor window open |
| busy | output | 1 | Sequence in progress |
| stepValid | output | 1 | Step result strobe |
| stepNum | output | 5 | List position of the reported step |
| stepPass | output | 1 | Reported step passed |
| overallPass | output | 1 | Whole-sequence result |
| done | output | 1 | Sequence completed (one-cycle pulse) |

## Verification
`patSel`, `monEn` and `busy` change one cycle after the clock that samples a start command or a step's closing tick. The step report, `done` and the updated `overallPass` are due one cycle after the clock that samples the closing tick. The bench drives every input and samples every output on falling edges. A tick is held for one cycle, so each reading reflects exactly the ticks already sampled. Expected reports are queued when each step begins, and a monitor process compares them on the falling edge where `stepValid` is high. Any report that arrives with nothing queued counts as a failure.

// File: rtl/tseq_pkg.sv
package tseq_pkg;

  typedef enum logic [1:0] {
    SEQ_QUICK  = 2'd0,
    SEQ_LONG   = 2'd1,
    SEQ_MULTI  = 2'd2,
    SEQ_BRIDGE = 2'd3
  } seqKind_e;

  localparam int PAT_W  = 4;
  localparam int STEP_W = 5;

  localparam logic [PAT_W-1:0] PAT_ALL_ONES   = 4'd0;
  localparam logic [PAT_W-1:0] PAT_ONE_IN_8   = 4'd1;
  localparam logic [PAT_W-1:0] PAT_TWO_IN_8   = 4'd2;
  localparam logic [PAT_W-1:0] PAT_THREE_24   = 4'd3;
  localparam logic [PAT_W-1:0] PAT_PRBS20Q    = 4'd4;
  localparam logic [PAT_W-1:0] PAT_ALL_ZEROS  = 4'd5;
  localparam logic [PAT_W-1:0] PAT_OCT_FRAMED = 4'd6;
  localparam logic [PAT_W-1:0] PAT_OCT_OPEN   = 4'd7;
  localparam int OCT_CODES = 8;

  // list position of the all-zeros step in the quick/long list
  localparam logic [STEP_W-1:0] ZERO_POS = 5'd4;

  typedef struct packed {
    logic clearAll;
    logic stepEnd;
    logic seqEnd;
    logic monOpen;
  } ctlStrobe_t;

  function automatic logic [STEP_W-1:0] stepsIn(seqKind_e k);
    case (k)
      SEQ_MULTI:  return 5'd5;
      SEQ_BRIDGE: return 5'd21;
      default:    return 5'd7;
    endcase
  endfunction

  function automatic logic [PAT_W-1:0] patternAt(seqKind_e k, logic [STEP_W-1:0] idx);
    logic [STEP_W-1:0] rel;
    rel = idx - 5'd1;
    case (k)
      SEQ_MULTI: return idx[PAT_W-1:0];
      SEQ_BRIDGE: begin
        if (idx == 5'd0)       return PAT_ALL_ONES;
        else if (idx == 5'd20) return PAT_PRBS20Q;
        else                   return PAT_OCT_FRAMED + {1'b0, rel[2:0]};
      end
      default: begin
        case (idx)
          5'd0:    return PAT_THREE_24;
          5'd1:    return PAT_ONE_IN_8;
          5'd2:    return PAT_PRBS20Q;
          5'd3:    return PAT_ALL_ONES;
          5'd4:    return PAT_ALL_ZEROS;
          5'd5:    return PAT_OCT_FRAMED;
          default: return PAT_OCT_OPEN;
        endcase
      end
    endcase
  endfunction

endpackage

// File: rtl/tseq_ctrl.sv
module tseq_ctrl
  import tseq_pkg::*;
#(
  parameter int SEC_W      = 16,
  parameter int QUICK_TX   = 5,
  parameter int MULTI_TX   = 180,
  parameter int MULTI_MON  = 175,
  parameter int BRIDGE_TX  = 30,
  parameter int BRIDGE_MON = 23
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        seqSel,
  input  logic              start,
  input  logic              secTick,
  input  logic              b8zsOn,
  input  logic [SEC_W-1:0]  longSecs,
  output logic [PAT_W-1:0]  patSel,
  output logic [STEP_W-1:0] stepIdx,
  output logic              busy,
  output ctlStrobe_t        strobe
);

  localparam logic [SEC_W-1:0] MULTI_GUARD  = SEC_W'(MULTI_TX - MULTI_MON);
  localparam logic [SEC_W-1:0] BRIDGE_GUARD = SEC_W'(BRIDGE_TX - BRIDGE_MON);

  logic              running;
  seqKind_e          seqCur;
  logic              b8zsCur;
  logic [SEC_W-1:0]  longCur;
  logic [SEC_W-1:0]  secCnt;
  logic [SEC_W-1:0]  txLen;
  logic [SEC_W-1:0]  guardLen;
  logic [STEP_W-1:0] nextIdx;
  logic              lastTick;
  logic              lastStep;

  always_comb begin
    case (seqCur)
      SEQ_QUICK: begin
        txLen    = SEC_W'(QUICK_TX);
        guardLen = '0;
      end
      SEQ_LONG: begin
        txLen    = (longCur == '0) ? SEC_W'(1) : longCur;
        guardLen = '0;
      end
      SEQ_MULTI: begin
        txLen    = SEC_W'(MULTI_TX);
        guardLen = MULTI_GUARD;
      end
      default: begin
        txLen    = SEC_W'(BRIDGE_TX);
        guardLen = BRIDGE_GUARD;
      end
    endcase
  end

  always_comb begin
    nextIdx = stepIdx + 5'd1;
    if ((seqCur == SEQ_QUICK || seqCur == SEQ_LONG) && nextIdx == ZERO_POS && !b8zsCur)
      nextIdx = stepIdx + 5'd2;
  end

  assign lastTick = running && secTick && (secCnt == txLen - SEC_W'(1));
  assign lastStep = nextIdx >= stepsIn(seqCur);

  always_comb begin
    strobe.clearAll = start;
    strobe.stepEnd  = lastTick && !start;
    strobe.seqEnd   = lastTick && !start && lastStep;
    strobe.monOpen  = running && (secCnt >= guardLen);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      seqCur  <= SEQ_QUICK;
      b8zsCur <= 1'b0;
      longCur <= '0;
      stepIdx <= '0;
      secCnt  <= '0;
    end else if (start) begin
      running <= 1'b1;
      seqCur  <= seqKind_e'(seqSel);
      b8zsCur <= b8zsOn;
      longCur <= longSecs;
      stepIdx <= '0;
      secCnt  <= '0;
    end else if (lastTick) begin
      secCnt <= '0;
      if (lastStep) begin
        running <= 1'b0;
        stepIdx <= '0;
      end else begin
        stepIdx <= nextIdx;
      end
    end else if (running && secTick) begin
      secCnt <= secCnt + SEC_W'(1);
    end
  end

  assign patSel = running ? patternAt(seqCur, stepIdx) : PAT_ALL_ONES;
  assign busy   = running;

  // R6: the step position stays inside the selected list
  assert_step_in_list_R6: assert property (@(posedge clk) disable iff (!rstN)
    running |-> stepIdx < stepsIn(seqCur));

  // R3: zero pattern never driven when substitution was off at start
  assert_zeros_skipped_R3: assert property (@(posedge clk) disable iff (!rstN)
    (running && (seqCur == SEQ_QUICK || seqCur == SEQ_LONG) && !b8zsCur)
      |-> patSel != PAT_ALL_ZEROS);

  // R5: the second counter never passes the step length
  assert_sec_bounded_R5: assert property (@(posedge clk) disable iff (!rstN)
    running |-> secCnt < txLen);

  // R10: a start command always leaves the block running at position 0
  assert_restart_R10: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (busy && stepIdx == '0));

endmodule

// File: rtl/tseq_results.sv
module tseq_results
  import tseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              errStrobe,
  input  logic [STEP_W-1:0] stepIdx,
  output logic              stepValid,
  output logic [STEP_W-1:0] stepNum,
  output logic              stepPass,
  output logic              overallPass,
  output logic              done
);

  logic errSeen;
  logic hitNow;
  logic stepBad;

  assign hitNow  = strobe.monOpen && errStrobe;
  assign stepBad = errSeen || hitNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errSeen     <= 1'b0;
      stepValid   <= 1'b0;
      stepNum     <= '0;
      stepPass    <= 1'b0;
      overallPass <= 1'b0;
      done        <= 1'b0;
    end else if (strobe.clearAll) begin
      errSeen     <= 1'b0;
      stepValid   <= 1'b0;
      stepPass    <= 1'b0;
      overallPass <= 1'b1;
      done        <= 1'b0;
    end else begin
      stepValid <= strobe.stepEnd;
      done      <= strobe.seqEnd;
      if (strobe.stepEnd) begin
        stepNum     <= stepIdx;
        stepPass    <= !stepBad;
        overallPass <= overallPass && !stepBad;
        errSeen     <= 1'b0;
      end else if (hitNow) begin
        errSeen <= 1'b1;
      end
    end
  end

  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: completion coincides with the final step report
  assert_done_with_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> stepValid);

  // R9: a failing step report drags the overall result low
  assert_fail_sticks_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && !stepPass) |-> !overallPass);

  // R8: a report is never two cycles long
  assert_report_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && $past(stepValid)) |-> stepNum != $past(stepNum));

endmodule

// File: rtl/test_seq_ctrl.sv
module test_seq_ctrl
  import tseq_pkg::*;
#(
  parameter int SEC_W      = 16,
  parameter int QUICK_TX   = 5,
  parameter int MULTI_TX   = 180,
  parameter int MULTI_MON  = 175,
  parameter int BRIDGE_TX  = 30,
  parameter int BRIDGE_MON = 23
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       seqSel,
  input  logic             start,
  input  logic             secTick,
  input  logic             b8zsOn,
  input  logic [SEC_W-1:0] longSecs,
  input  logic             errStrobe,
  output logic [3:0]       patSel,
  output logic             monEn,
  output logic             busy,
  output logic             stepValid,
  output logic [4:0]       stepNum,
  output logic             stepPass,
  output logic             overallPass,
  output logic             done
);

  ctlStrobe_t        strobe;
  logic [STEP_W-1:0] stepIdx;

  tseq_ctrl #(
    .SEC_W(SEC_W), .QUICK_TX(QUICK_TX), .MULTI_TX(MULTI_TX),
    .MULTI_MON(MULTI_MON), .BRIDGE_TX(BRIDGE_TX), .BRIDGE_MON(BRIDGE_MON)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .seqSel(seqSel), .start(start),
    .secTick(secTick), .b8zsOn(b8zsOn), .longSecs(longSecs),
    .patSel(patSel), .stepIdx(stepIdx), .busy(busy), .strobe(strobe)
  );

  tseq_results u_results (
    .clk(clk), .rstN(rstN), .strobe(strobe), .errStrobe(errStrobe),
    .stepIdx(stepIdx), .stepValid(stepValid), .stepNum(stepNum),
    .stepPass(stepPass), .overallPass(overallPass), .done(done)
  );

  assign monEn = strobe.monOpen;

endmodule

// File: tb/test_seq_ctrl_bench.sv
module test_seq_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  seqSel = 2'd0;
  logic        start = 1'b0;
  logic        secTick = 1'b0;
  logic        b8zsOn = 1'b0;
  logic [15:0] longSecs = 16'd0;
  logic        errStrobe = 1'b0;
  logic [3:0]  patSel;
  logic        monEn, busy, stepValid, stepPass, overallPass, done;
  logic [4:0]  stepNum;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  typedef struct {
    int num;
    bit pass;
    bit last;
    bit overall;
  } expRep_t;
  expRep_t expQ[$];

  always #2.5 clk = ~clk;

  test_seq_ctrl u_test_seq_ctrl (
    .clk(clk), .rstN(rstN), .seqSel(seqSel), .start(start),
    .secTick(secTick), .b8zsOn(b8zsOn), .longSecs(longSecs),
    .errStrobe(errStrobe), .patSel(patSel), .monEn(monEn), .busy(busy),
    .stepValid(stepValid), .stepNum(stepNum), .stepPass(stepPass),
    .overallPass(overallPass), .done(done)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expPat(int sel, int p);
    if (sel <= 1) begin
      case (p)
        0: return 3;
        1: return 1;
        2: return 4;
        3: return 0;
        4: return 5;
        5: return 6;
        default: return 7;
      endcase
    end else if (sel == 2) return p;
    else if (p == 0) return 0;
    else if (p == 20) return 4;
    else return 6 + ((p - 1) % 8);
  endfunction

  function automatic int stepCount(int sel);
    return (sel == 2) ? 5 : (sel == 3) ? 21 : 7;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && done && !stepValid)
      check(0, "R9", "done without step report", 1, 0);
    if (rstN && stepValid) begin
      if (expQ.size() == 0) begin
        check(0, "R8", "unexpected step report", stepNum, -1);
      end else begin
        expRep_t e;
        e = expQ.pop_front();
        check(stepNum == e.num, "R8", "stepNum", stepNum, e.num);
        check(stepPass == e.pass, "R7", "stepPass", stepPass, e.pass);
        check(done == e.last, "R9", "done", done, e.last);
        check(overallPass == e.overall, "R9", "overallPass", overallPass, e.overall);
      end
    end
  end

  task automatic pulseStart(int sel, bit bz, int lng);
    @(negedge clk);
    seqSel = sel[1:0]; b8zsOn = bz; longSecs = lng[15:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // one second: check outputs, then a one-cycle tick (optionally with an error)
  task automatic doSecond(int pat, bit mon, bit err, string req);
    check(patSel == pat[3:0], req, "patSel", patSel, pat);
    check(monEn == mon, req, "monEn", monEn, mon);
    secTick = 1'b1; errStrobe = err;
    @(negedge clk);
    secTick = 1'b0; errStrobe = 1'b0;
  endtask

  task automatic runSeq(int sel, bit bz, int lng, int failStep, int errSec, string req);
    int tx, guard, total, lastPos;
    bit overall;
    tx    = (sel == 0) ? 5 : (sel == 1) ? ((lng == 0) ? 1 : lng) : (sel == 2) ? 180 : 30;
    guard = (sel == 2) ? 5 : (sel == 3) ? 7 : 0;
    total = stepCount(sel);
    lastPos = total - 1;
    overall = 1;
    pulseStart(sel, bz, lng);
    for (int p = 0; p < total; p++) begin
      expRep_t e;
      bit pass;
      if (sel <= 1 && p == 4 && !bz) continue;  // R3 skip
      pass = !(p == failStep && errSec >= guard);
      overall = overall && pass;
      e.num = p; e.pass = pass; e.last = (p == lastPos); e.overall = overall;
      expQ.push_back(e);
      for (int s = 0; s < tx; s++)
        doSecond(expPat(sel, p), s >= guard, (p == failStep && s == errSec), req);
    end
    // report is sampled by the monitor on this negedge
    check(busy == 1'b0, "R9", "busy after completion", busy, 0);
    @(negedge clk);
    check(expQ.size() == 0, "R8", "reports outstanding", expQ.size(), 0);
    check(overallPass == overall, "R9", "overallPass held", overallPass, overall);
    check(done == 1'b0, "R9", "done single cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 0, "R1", "busy", busy, 0);
    check(monEn == 0, "R1", "monEn", monEn, 0);
    check(stepValid == 0, "R1", "stepValid", stepValid, 0);
    check(done == 0, "R1", "done", done, 0);
    check(overallPass == 0, "R1", "overallPass", overallPass, 0);
    check(patSel == 4'd0, "R1", "patSel", patSel, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0, "R1", "busy after release", busy, 0);

    // R2: quick with zeros step, error in step 0 -> fail (R7)
    runSeq(0, 1, 0, 0, 4, "R2");
    // R3: quick without substitution, zeros step skipped
    runSeq(0, 0, 0, -1, 0, "R3");
    // R4: long, 3-second steps, zeros step fails on first second
    runSeq(1, 1, 3, 4, 0, "R4");
    // R4: long with length 0 treated as 1
    runSeq(1, 0, 0, 6, 0, "R4");
    // R5 and R7: multiple, error inside guard seconds is ignored
    runSeq(2, 1, 0, 2, 4, "R5");
    // R6 and R7: bridge, error in first monitored second of the last step
    runSeq(3, 0, 0, 20, 7, "R6");

    // R10: restart mid-step after an error; aborted step not reported
    pulseStart(0, 1, 0);
    doSecond(3, 1, 0, "R10");
    doSecond(3, 1, 1, "R10");
    doSecond(3, 1, 0, "R10");
    // tick coinciding with the restart is ignored
    @(negedge clk);
    start = 1'b1; secTick = 1'b1;
    @(negedge clk);
    start = 1'b0; secTick = 1'b0;
    check(overallPass == 1, "R10", "overallPass cleared by restart", overallPass, 1);
    check(busy == 1, "R10", "busy after restart", busy, 1);
    for (int p = 0; p < 7; p++) begin
      expRep_t e;
      e.num = p; e.pass = 1; e.last = (p == 6); e.overall = 1;
      expQ.push_back(e);
      for (int s = 0; s < 5; s++) doSecond(expPat(0, p), 1, 0, "R10");
    end
    @(negedge clk);
    check(expQ.size() == 0, "R10", "reports outstanding", expQ.size(), 0);
    check(overallPass == 1, "R10", "overallPass after clean rerun", overallPass, 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule